// File: doc/BRIEF.md
# ADC serial output and power-mode sequencer

This block is the digital interface logic of a successive-approximation converter, written as a synthesizable model that a host serial controller can be verified against. A host drives a convert-start strobe and a serial clock. The block samples both with an oversampling system clock, counts the serial-clock edges of each frame, and shifts a supplied conversion result out on a data pin that can be tri-stated. The result is a 10-bit word plus two sub-bits, taken from a parallel input. No analog circuitry is modelled.

Besides the data path, the block keeps the track/hold state, the power mode and the reference-enable flag. The power mode is normal, partial power-down or full power-down. It changes only according to the serial-clock edge count at which the strobe returns high. A calibration-pending flag marks that no complete conversion has happened since the hardware reset. Status outputs expose the mode, the reference flag, the track/hold state and the calibration flag, so that a bench can compare them with its own model.

The two asynchronous inputs pass through a synchronizer and an edge detector. A rise or fall on a pin therefore takes effect on the outputs three system clocks later, with the default two synchronizer stages. The host must hold each serial-clock level for longer than that.

Top module: `adc_serial_seq`

## Requirements
- R1: A strobe falling edge starts a frame. The edge count is cleared, hold_o goes to 1 (hold), sdo_oe_o goes to 1 and sdo_o is driven 0. The result and sub-bit inputs are captured at this moment.
- R2: After serial-clock rising edge k of a frame, sdo_o carries 0 for k = 1..3, result bit 13-k for k = 4..13 (MSB first), sub-bit 1 for k = 14, sub-bit 0 for k = 15, and 0 from k = 16 on.
- R3: hold_o stays 1 through rising edges 1..13 and returns to 0 (track) on the 14th rising edge. It stays 0 while no frame is running.
- R4: When the strobe is still low at the 16th serial-clock falling edge, sdo_oe_o stays 1 until the next serial-clock rise or the next strobe rise, whichever comes first. It then drops to 0.
- R5: A strobe rise after 14 or more rising edges, before the 16th falling edge has been seen low, leaves sdo_oe_o at 1 and arms the next conversion.
- R6: A strobe rise after at least 3 and fewer than 14 rising edges steps mode_o from 0 (normal) to 1 (partial power-down), and from 1 to 2 (full power-down). Mode 2 stays 2. The same rise drops sdo_oe_o to 0. ref_en_o is 1 in modes 0 and 1 and 0 in mode 2.
- R7: In mode 1 or 2, a strobe rise after 14 or more rising edges returns mode_o to 0 and sets ref_en_o to 1.
- R8: A strobe rise after fewer than 3 rising edges drops sdo_oe_o to 0 and leaves mode_o unchanged.
- R9: Reset sets cal_pend_o to 1. The 16th rising edge of any frame clears it. Leaving a power-down mode does not set it again.
- R10: Serial-clock edges outside a frame leave sdo_oe_o at 0, sdo_o at 0 and hold_o at 0.
- R11: After reset: sdo_oe_o = 0, sdo_o = 0, hold_o = 0, mode_o = 0, ref_en_o = 1, cal_pend_o = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling system clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| cnv_i | input | 1 | Convert-start strobe, asynchronous, idles high |
| sclk_i | input | 1 | Serial clock from the host, asynchronous |
| result_i | input | DATA_W | Parallel conversion result |
| sub_i | input | SUB_W | Sub-bits sent after the result |
| sdo_o | output | 1 | Serial data value |
| sdo_oe_o | output | 1 | Data output enable (0 means high impedance) |
| mode_o | output | 2 | Power mode: 0 normal, 1 partial, 2 full power-down |
| ref_en_o | output | 1 | Reference-enable flag |
| hold_o | output | 1 | 1 while the track/hold is in hold |
| cal_pend_o | output | 1 | Calibration pending since reset |

## Verification
A wrong edge count shows first on sdo_o: every result bit after the faulty edge is shifted by one position, and the error appears three system clocks after the serial-clock rise that caused it. Counter errors near the thresholds also move the edge at which hold_o falls or the window in which a strobe rise is taken as a power-down request. The bench therefore sees a wrong mode_o and sdo_oe_o three clocks after that strobe rise. A wrong mode register changes ref_en_o at once, and a power-down or exit request goes to the wrong mode on the next frame. A calibration flag that never clears, or that is set again, stays visible on cal_pend_o until the next reset.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

   typedef enum logic [1:0] {
      PM_NORMAL  = 2'd0,
      PM_PARTIAL = 2'd1,
      PM_FULL    = 2'd2
   } pmode_t;

endpackage

// File: rtl/adc_edge_sync.sv
module adc_edge_sync #(
   parameter int   STAGES = 2,
   parameter logic IDLE   = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic rise_o,
   output logic fall_o
);
   logic [STAGES-1:0] sh;
   logic              prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh   <= {STAGES{IDLE}};
         prev <= IDLE;
      end else begin
         sh   <= {sh[STAGES-2:0], din};
         prev <= sh[STAGES-1];
      end
   end

   assign rise_o = sh[STAGES-1] & ~prev;
   assign fall_o = ~sh[STAGES-1] & prev;
endmodule

// File: rtl/adc_frame_ctrl.sv
module adc_frame_ctrl #(
   parameter int DATA_W     = 10,
   parameter int SUB_W      = 2,
   parameter int LEAD_ZEROS = 3,
   parameter int TRACK_EDGE = 14,
   parameter int CNT_W      = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cnv_rise,
   input  logic              cnv_fall,
   input  logic              sclk_rise,
   input  logic              sclk_fall,
   input  logic [DATA_W-1:0] result_i,
   input  logic [SUB_W-1:0]  sub_i,
   output logic              sdo_o,
   output logic              oe_o,
   output logic              hold_o,
   output logic              active_o,
   output logic [CNT_W-1:0]  cnt_o,
   output logic              done_o
);
   localparam int WORD_W      = DATA_W + SUB_W;
   localparam int FRAME_EDGES = LEAD_ZEROS + WORD_W + 1;
   localparam logic [CNT_W-1:0] CNT_MAX = '1;
   localparam logic [CNT_W-1:0] TRK_C   = CNT_W'(TRACK_EDGE);
   localparam logic [CNT_W-1:0] FRM_C   = CNT_W'(FRAME_EDGES);

   logic              active, strobe_low, late, hold, oe, sdo, done;
   logic [CNT_W-1:0]  cnt, cnt_inc;
   logic [WORD_W-1:0] word;
   logic              nxt_bit;

   assign cnt_inc = (cnt == CNT_MAX) ? cnt : cnt + 1'b1;

   // bit that belongs to the position the next rising edge reaches
   always_comb begin
      nxt_bit = 1'b0;
      for (int j = 0; j < WORD_W; j++) begin
         if (cnt_inc == CNT_W'(LEAD_ZEROS + WORD_W - j)) nxt_bit = word[j];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active     <= 1'b0;
         strobe_low <= 1'b0;
         late       <= 1'b0;
         hold       <= 1'b0;
         oe         <= 1'b0;
         sdo        <= 1'b0;
         done       <= 1'b0;
         cnt        <= '0;
         word       <= '0;
      end else begin
         done <= 1'b0;
         if (cnv_fall) begin
            active     <= 1'b1;
            strobe_low <= 1'b1;
            late       <= 1'b0;
            hold       <= 1'b1;
            oe         <= 1'b1;
            sdo        <= 1'b0;
            cnt        <= '0;
            word       <= {result_i, sub_i};
         end else if (cnv_rise) begin
            strobe_low <= 1'b0;
            if (active && (cnt < TRK_C || late)) begin
               active <= 1'b0;
               late   <= 1'b0;
               hold   <= 1'b0;
               oe     <= 1'b0;
               sdo    <= 1'b0;
            end
         end else if (sclk_rise && active) begin
            if (late) begin
               active <= 1'b0;
               late   <= 1'b0;
               oe     <= 1'b0;
               sdo    <= 1'b0;
            end else begin
               cnt <= cnt_inc;
               sdo <= nxt_bit;
               if (cnt_inc == TRK_C) hold <= 1'b0;
               if (cnt_inc == FRM_C && cnt != FRM_C) done <= 1'b1;
            end
         end else if (sclk_fall && active && strobe_low && cnt == FRM_C) begin
            late <= 1'b1;
         end
      end
   end

   assign sdo_o    = sdo;
   assign oe_o     = oe;
   assign hold_o   = hold;
   assign active_o = active;
   assign cnt_o    = cnt;
   assign done_o   = done;
endmodule

// File: rtl/adc_power_fsm.sv
module adc_power_fsm
   import adc_seq_pkg::*;
#(
   parameter int PD_FROM    = 3,
   parameter int TRACK_EDGE = 14,
   parameter int EXIT_CLKS  = 14,
   parameter int CNT_W      = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cnv_rise,
   input  logic             active,
   input  logic [CNT_W-1:0] cnt,
   input  logic             done,
   output pmode_t           mode_o,
   output logic             ref_en_o,
   output logic             cal_pend_o
);
   localparam logic [CNT_W-1:0] PD_C   = CNT_W'(PD_FROM);
   localparam logic [CNT_W-1:0] TRK_C  = CNT_W'(TRACK_EDGE);
   localparam logic [CNT_W-1:0] EXIT_C = CNT_W'(EXIT_CLKS);

   pmode_t mode;
   logic   ref_en, cal;
   logic   pd_req, exit_req;

   assign pd_req   = cnv_rise && active && cnt >= PD_C && cnt < TRK_C;
   assign exit_req = cnv_rise && active && cnt >= EXIT_C;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode   <= PM_NORMAL;
         ref_en <= 1'b1;
         cal    <= 1'b1;
      end else begin
         if (done) cal <= 1'b0;
         if (pd_req) begin
            case (mode)
               PM_NORMAL:  mode <= PM_PARTIAL;
               PM_PARTIAL: begin
                  mode   <= PM_FULL;
                  ref_en <= 1'b0;
               end
               default:    mode <= PM_FULL;
            endcase
         end else if (exit_req) begin
            mode   <= PM_NORMAL;
            ref_en <= 1'b1;
         end
      end
   end

   assign mode_o     = mode;
   assign ref_en_o   = ref_en;
   assign cal_pend_o = cal;
endmodule

// File: rtl/adc_serial_seq.sv
module adc_serial_seq
   import adc_seq_pkg::*;
#(
   parameter int DATA_W      = 10,
   parameter int SUB_W       = 2,
   parameter int LEAD_ZEROS  = 3,
   parameter int TRACK_EDGE  = 14,
   parameter int PD_FROM     = 3,
   parameter int EXIT_CLKS   = 14,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cnv_i,
   input  logic              sclk_i,
   input  logic [DATA_W-1:0] result_i,
   input  logic [SUB_W-1:0]  sub_i,
   output logic              sdo_o,
   output logic              sdo_oe_o,
   output logic [1:0]        mode_o,
   output logic              ref_en_o,
   output logic              hold_o,
   output logic              cal_pend_o
);
   localparam int FRAME_EDGES = LEAD_ZEROS + DATA_W + SUB_W + 1;
   localparam int CNT_W       = $clog2(FRAME_EDGES + 1) + 1;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (TRACK_EDGE <= PD_FROM || TRACK_EDGE >= FRAME_EDGES) begin : g_bad_track
      $error("TRACK_EDGE must lie between PD_FROM and the frame length");
   end
   if (EXIT_CLKS < TRACK_EDGE || EXIT_CLKS > FRAME_EDGES) begin : g_bad_exit
      $error("EXIT_CLKS must not overlap the power-down window");
   end

   logic [1:0] pins, rise_v, fall_v;
   logic       sclk_rise, sclk_fall, cnv_rise, cnv_fall;
   logic       active, done, oe, sdo, hold;
   logic [CNT_W-1:0] cnt;
   pmode_t     mode;

   assign pins = {cnv_i, sclk_i};

   for (genvar i = 0; i < 2; i++) begin : g_sync
      adc_edge_sync #(.STAGES(SYNC_STAGES), .IDLE(i == 1)) u_sync (
         .clk    (clk),
         .rst_n  (rst_n),
         .din    (pins[i]),
         .rise_o (rise_v[i]),
         .fall_o (fall_v[i])
      );
   end

   assign sclk_rise = rise_v[0];
   assign sclk_fall = fall_v[0];
   assign cnv_rise  = rise_v[1];
   assign cnv_fall  = fall_v[1];

   adc_frame_ctrl #(
      .DATA_W(DATA_W), .SUB_W(SUB_W), .LEAD_ZEROS(LEAD_ZEROS),
      .TRACK_EDGE(TRACK_EDGE), .CNT_W(CNT_W)
   ) u_frame (
      .clk       (clk),
      .rst_n     (rst_n),
      .cnv_rise  (cnv_rise),
      .cnv_fall  (cnv_fall),
      .sclk_rise (sclk_rise),
      .sclk_fall (sclk_fall),
      .result_i  (result_i),
      .sub_i     (sub_i),
      .sdo_o     (sdo),
      .oe_o      (oe),
      .hold_o    (hold),
      .active_o  (active),
      .cnt_o     (cnt),
      .done_o    (done)
   );

   adc_power_fsm #(
      .PD_FROM(PD_FROM), .TRACK_EDGE(TRACK_EDGE),
      .EXIT_CLKS(EXIT_CLKS), .CNT_W(CNT_W)
   ) u_power (
      .clk        (clk),
      .rst_n      (rst_n),
      .cnv_rise   (cnv_rise),
      .active     (active),
      .cnt        (cnt),
      .done       (done),
      .mode_o     (mode),
      .ref_en_o   (ref_en_o),
      .cal_pend_o (cal_pend_o)
   );

   assign sdo_o    = sdo;
   assign sdo_oe_o = oe;
   assign hold_o   = hold;
   assign mode_o   = mode;
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       cnv_rise,
   input logic       cnv_fall,
   input logic       sclk_rise,
   input logic       sdo,
   input logic       oe,
   input logic       hold,
   input logic [1:0] mode,
   input logic       ref_en,
   input logic       cal_pend
);
   AST_START_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
      cnv_fall |=> (oe && hold && !sdo)); // R1
   AST_OE_ONLY_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(oe) |-> $past(cnv_fall)); // R10
   AST_HOLD_DROP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(hold) |-> ($past(sclk_rise) || $past(cnv_rise))); // R3
   AST_OE_DROP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(oe) |-> ($past(sclk_rise) || $past(cnv_rise))); // R4
   AST_FULL_VIA_PARTIAL: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'd2 && $past(mode) != 2'd2) |-> $past(mode) == 2'd1); // R6
   AST_REF_FOLLOWS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
      ref_en == (mode != 2'd2)); // R6
   AST_MODE_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(mode) |-> $past(cnv_rise)); // R7
   AST_CAL_ONE_WAY: assert property (@(posedge clk) disable iff (!rst_n)
      !cal_pend |=> !cal_pend); // R9
endmodule

bind adc_serial_seq adc_seq_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cnv_rise  (cnv_rise),
   .cnv_fall  (cnv_fall),
   .sclk_rise (sclk_rise),
   .sdo       (sdo),
   .oe        (oe),
   .hold      (hold),
   .mode      (mode_o),
   .ref_en    (ref_en_o),
   .cal_pend  (cal_pend_o)
);

// File: tb/sim_adc_serial_seq.sv
module sim_adc_serial_seq;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cnv = 1'b1;
   logic       sclk = 1'b0;
   logic [9:0] result = '0;
   logic [1:0] sub = '0;
   logic       sdo, sdo_oe, ref_en, hold, cal_pend;
   logic [1:0] mode;

   int total = 0;
   int fails = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   adc_serial_seq u0 (
      .clk(clk), .rst_n(rst_n), .cnv_i(cnv), .sclk_i(sclk),
      .result_i(result), .sub_i(sub),
      .sdo_o(sdo), .sdo_oe_o(sdo_oe), .mode_o(mode),
      .ref_en_o(ref_en), .hold_o(hold), .cal_pend_o(cal_pend)
   );

   typedef struct packed {
      logic [9:0] d;
      logic [1:0] s;
      logic [4:0] nrise;
      logic [4:0] rpt;   // strobe rises after this pulse; > nrise: stays low
      logic       oe;
      logic [1:0] mode;
   } vec_t;

   localparam vec_t VECS [10] = '{
      '{10'h2A5, 2'd2, 5'd16, 5'd15, 1'b1, 2'd0},
      '{10'h155, 2'd1, 5'd14, 5'd14, 1'b1, 2'd0},
      '{10'h3FF, 2'd3, 5'd16, 5'd20, 1'b0, 2'd0},
      '{10'h000, 2'd0, 5'd8,  5'd8,  1'b0, 2'd1},
      '{10'h0F0, 2'd2, 5'd14, 5'd14, 1'b1, 2'd0},
      '{10'h30C, 2'd1, 5'd5,  5'd5,  1'b0, 2'd1},
      '{10'h1E7, 2'd3, 5'd10, 5'd10, 1'b0, 2'd2},
      '{10'h2DB, 2'd0, 5'd4,  5'd4,  1'b0, 2'd2},
      '{10'h19A, 2'd2, 5'd16, 5'd15, 1'b1, 2'd0},
      '{10'h333, 2'd1, 5'd2,  5'd2,  1'b0, 2'd0}
   };

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic exp_bit(int k, logic [9:0] d, logic [1:0] s);
      if (k >= 4 && k <= 13) return d[13-k];
      if (k == 14) return s[1];
      if (k == 15) return s[0];
      return 1'b0;
   endfunction

   task automatic wait_clk(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_rise(int k, logic [9:0] d, logic [1:0] s, bit chk_data);
      sclk = 1'b1;
      wait_clk(6);
      if (chk_data) begin
         chk(sdo, exp_bit(k, d, s), $sformatf("R2 bit after rise %0d", k));
         chk(hold, (k < 14), $sformatf("R3 hold after rise %0d", k));
      end
      sclk = 1'b0;
      wait_clk(6);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      cnv = 1'b1;
      sclk = 1'b0;
      wait_clk(4);
      rst_n = 1'b1;
      wait_clk(4);
   endtask

   initial begin
      do_reset();
      // R11: reset state
      chk(sdo_oe, 1'b0, "R11 oe after reset");
      chk(sdo, 1'b0, "R11 sdo after reset");
      chk(hold, 1'b0, "R11 hold after reset");
      chk(mode, 2'd0, "R11 mode after reset");
      chk(ref_en, 1'b1, "R11 ref after reset");
      chk(cal_pend, 1'b1, "R11 cal after reset");

      // R10: serial clock without a frame is ignored
      for (int k = 1; k <= 3; k++) pulse_rise(k, '0, '0, 1'b0);
      chk(sdo_oe, 1'b0, "R10 oe idle clocks");
      chk(sdo, 1'b0, "R10 sdo idle clocks");
      chk(hold, 1'b0, "R10 hold idle clocks");

      // table-driven frames
      for (int i = 0; i < 10; i++) begin
         vec_t v;
         v = VECS[i];
         result = v.d;
         sub = v.s;
         cnv = 1'b0;
         wait_clk(8);
         chk(hold, 1'b1, $sformatf("R1 hold at start v%0d", i));
         chk(sdo_oe, 1'b1, $sformatf("R1 oe at start v%0d", i));
         chk(sdo, 1'b0, $sformatf("R1 sdo at start v%0d", i));
         result = ~v.d;   // later changes must not reach the frame
         for (int k = 1; k <= int'(v.nrise); k++) begin
            pulse_rise(k, v.d, v.s, 1'b1);
            if (k == int'(v.rpt)) begin
               cnv = 1'b1;
               wait_clk(8);
            end
         end
         if (int'(v.rpt) > int'(v.nrise)) begin
            chk(sdo_oe, 1'b1, $sformatf("R4 still driven after 16th fall v%0d", i));
            pulse_rise(17, v.d, v.s, 1'b0);
            chk(sdo_oe, 1'b0, $sformatf("R4 released by sclk rise v%0d", i));
            cnv = 1'b1;
            wait_clk(8);
         end
         chk(sdo_oe, v.oe, $sformatf("R5 R6 R8 oe after frame v%0d", i));
         chk(mode, v.mode, $sformatf("R6 R7 mode after frame v%0d", i));
         chk(ref_en, (v.mode != 2'd2), $sformatf("R6 ref after frame v%0d", i));
         chk(cal_pend, 1'b0, $sformatf("R9 cal cleared v%0d", i));
      end

      // R4: strobe rise releases the output after the 16th fall
      result = 10'h0AA;
      sub = 2'd1;
      cnv = 1'b0;
      wait_clk(8);
      for (int k = 1; k <= 16; k++) pulse_rise(k, 10'h0AA, 2'd1, 1'b1);
      chk(sdo_oe, 1'b1, "R4 driven before strobe rise");
      cnv = 1'b1;
      wait_clk(8);
      chk(sdo_oe, 1'b0, "R4 released by strobe rise");
      chk(hold, 1'b0, "R3 track between conversions");

      // R9: enter partial power-down, leave it, calibration stays clear
      cnv = 1'b0;
      wait_clk(8);
      for (int k = 1; k <= 6; k++) pulse_rise(k, 10'h0AA, 2'd1, 1'b0);
      cnv = 1'b1;
      wait_clk(8);
      chk(mode, 2'd1, "R6 partial entry");
      cnv = 1'b0;
      wait_clk(8);
      for (int k = 1; k <= 14; k++) pulse_rise(k, 10'h0AA, 2'd1, 1'b0);
      cnv = 1'b1;
      wait_clk(8);
      chk(mode, 2'd0, "R7 exit to normal");
      chk(cal_pend, 1'b0, "R9 cal not set by exit");

      // R9, R11: hardware reset sets calibration again
      do_reset();
      chk(cal_pend, 1'b1, "R9 cal set by reset");
      chk(mode, 2'd0, "R11 mode after second reset");

      finished = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         total++;
         fails++;
         $display("FAIL watchdog R1 actual=timeout expected=finish");
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end
endmodule